// File: doc/BRIEF.md
# Float and Integer Conversion Unit

This unit converts between IEEE-754 single-precision numbers and 32-bit integers in both directions. The caller supplies a 3-bit opcode, a 1-bit modifier and a 2-bit rounding mode, the last standing in for the dynamic mode of a floating-point status register. Source and destination are separate words, and the result comes back one clock after the request, together with invalid and inexact flags.

The modifier bit has a different meaning in each direction. For float-to-integer it forces round-toward-zero when set and follows the dynamic mode when clear. For integer-to-float it marks the source as signed when set and unsigned when clear. Integer-to-float always rounds with the dynamic mode. An opcode the unit does not know raises an undefined-operation output and returns zero.

Top module: `flt_int_cvt`

## Requirements
- R1: Opcode 3'b101 converts float to signed integer, 3'b100 converts float to unsigned integer, 3'b000 converts integer to float. Any other opcode gives result 0, clears invalid and inexact, and sets undefined.
- R2: A request accepted with in_valid high appears on the outputs after the next rising clock edge, with out_valid high for that one cycle. With in_valid low, out_valid goes low and result and flags hold their values.
- R3: For float to integer, in_mode_bit = 1 forces round-toward-zero and in_mode_bit = 0 uses in_rmode. The in_rmode encoding is 2'b00 nearest-even, 2'b01 toward +infinity, 2'b10 toward -infinity, 2'b11 toward zero.
- R4: Nearest-even rounding sends an exact half-way value to the even integer: 2.5 gives 2 and 3.5 gives 4.
- R5: A signed conversion outside the range -2^31 to 2^31-1 after rounding returns 0x7FFFFFFF for positive inputs and 0x80000000 for negative ones, with invalid set and inexact clear. -2^31 itself converts exactly.
- R6: For an unsigned conversion, a value above 0xFFFFFFFF after rounding returns 0xFFFFFFFF with invalid. A negative value that rounds to a non-zero magnitude returns 0 with invalid. A negative value that rounds to zero returns 0 with only inexact, or with no flag for -0.
- R7: A NaN source converts to 0 with invalid. An infinity saturates as in R5 and R6, with invalid.
- R8: A float-to-integer result that is in range sets inexact exactly when a non-zero fraction was discarded. This includes subnormal inputs.
- R9: For integer to float, in_mode_bit = 1 reads the source as two's complement and in_mode_bit = 0 reads it as unsigned. The result is the correctly signed IEEE single value, and a zero source gives +0.
- R10: Integer to float rounds with in_rmode. It sets inexact when set bits beyond the 24-bit significand are dropped. A rounding carry out of the significand raises the exponent by one.
- R11: While reset is asserted, and until the first request after reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_opc | input | 3 | Conversion opcode |
| in_mode_bit | input | 1 | Forced truncation (float source) or signed source (integer source) |
| in_rmode | input | 2 | Dynamic rounding mode |
| in_operand | input | 32 | Source word |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_result | output | 32 | Converted word |
| out_invalid | output | 1 | Invalid-operation flag |
| out_inexact | output | 1 | Inexact flag |
| out_undef | output | 1 | Unknown opcode |

## Verification
The bench goes after the edges of the integer ranges: exactly 2^31, exactly -2^31 and the next single value beyond it, and 2^32 for unsigned. A design with an off-by-one in its range check would saturate a legal -2^31 or wrap 2^31 to a negative number. Half-way ties under nearest-even, small negative fractions sent to unsigned under each rounding mode, and subnormals expose a wrong guard or sticky bit, which shows up as an odd result on a tie or as a missing inexact flag or a spurious invalid flag. On the integer side, 0xFFFFFFFF (unsigned) must round up to 2^32 through a significand carry, and 0x80000000 (signed) must keep its sign. A unit that lost the carry or negated the wrong operand returns a wrong exponent or a positive value.

// File: rtl/fic_pkg.sv
package fic_pkg;
  localparam int INT_W  = 32;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_UP   = 2'b01,
    RM_DOWN = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef enum logic [2:0] {
    OPC_I2F = 3'b000,
    OPC_F2U = 3'b100,
    OPC_F2S = 3'b101
  } opc_e;

  typedef struct packed {
    logic [INT_W-1:0] value;
    logic             invalid;
    logic             inexact;
  } cvt_res_t;
endpackage

// File: rtl/fic_round_dec.sv
module fic_round_dec
  import fic_pkg::*;
(
  input  rmode_e mode,
  input  logic   neg,
  input  logic   lsb,
  input  logic   guard,
  input  logic   sticky,
  output logic   incr
);
  always_comb begin
    case (mode)
      RM_NEAR: incr = guard & (sticky | lsb);
      RM_UP:   incr = (guard | sticky) & ~neg;
      RM_DOWN: incr = (guard | sticky) & neg;
      default: incr = 1'b0;
    endcase
  end
endmodule

// File: rtl/fic_lzc.sv
module fic_lzc #(
  parameter  int W  = 32,
  localparam int ZW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic [ZW-1:0] zeros
);
  // Ascending scan: the last hit is the highest set bit.
  always_comb begin
    zeros = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) zeros = ZW'(W - 1 - i);
    end
  end
endmodule

// File: rtl/fic_f2i.sv
module fic_f2i
  import fic_pkg::*;
(
  input  logic [INT_W-1:0] operand,
  input  logic             to_signed,
  input  rmode_e           mode,
  output cvt_res_t         res
);
  localparam int SIG_W     = FRAC_W + 1;
  localparam int FX_W      = 2 * INT_W;
  localparam int SH_W      = $clog2(FX_W);
  localparam int UNB_W     = EXP_W + 2;
  localparam int BIAS      = (1 << (EXP_W - 1)) - 1;
  localparam int SHIFT_OFF = INT_W - FRAC_W;
  localparam logic [INT_W:0] POS_MAX = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic [INT_W:0] NEG_MAG = {2'b01, {(INT_W-1){1'b0}}};

  logic                    sgn;
  logic [EXP_W-1:0]        ex;
  logic [FRAC_W-1:0]       fr;
  logic                    is_nan, is_inf, tiny, huge;
  logic signed [UNB_W-1:0] unb;
  logic [SH_W-1:0]         sh;
  logic [FX_W-1:0]         fx;
  logic [INT_W-1:0]        ipart;
  logic                    gbit, sbit, incr;
  logic [INT_W:0]          mag;
  logic [INT_W-1:0]        sat_val;

  assign sgn = operand[INT_W-1];
  assign ex  = operand[INT_W-2 -: EXP_W];
  assign fr  = operand[FRAC_W-1:0];

  always_comb begin
    unb    = $signed({2'b00, ex}) - $signed(UNB_W'(BIAS));
    is_nan = (&ex) && (|fr);
    is_inf = (&ex) && !(|fr);
    tiny   = (ex == '0) || (int'(unb) < -SHIFT_OFF);
    huge   = !(&ex) && (int'(unb) > INT_W - 1);
    sh     = (tiny || huge) ? '0 : SH_W'(int'(unb) + SHIFT_OFF);
    fx     = {{(FX_W-SIG_W){1'b0}}, 1'b1, fr} << sh;
    if (tiny) begin
      ipart = '0;
      gbit  = 1'b0;
      sbit  = (ex != '0) || (|fr);
    end else begin
      ipart = fx[FX_W-1:INT_W];
      gbit  = fx[INT_W-1];
      sbit  = |fx[INT_W-2:0];
    end
  end

  fic_round_dec u_round (
    .mode   (mode),
    .neg    (sgn),
    .lsb    (ipart[0]),
    .guard  (gbit),
    .sticky (sbit),
    .incr   (incr)
  );

  always_comb begin
    mag = {1'b0, ipart} + {{INT_W{1'b0}}, incr};
    if (to_signed) sat_val = sgn ? {1'b1, {(INT_W-1){1'b0}}} : {1'b0, {(INT_W-1){1'b1}}};
    else           sat_val = sgn ? '0 : '1;
  end

  always_comb begin
    res = '0;
    if (is_nan) begin
      res.invalid = 1'b1;
    end else if (is_inf || huge) begin
      res.invalid = 1'b1;
      res.value   = sat_val;
    end else if (to_signed) begin
      if ((!sgn && mag > POS_MAX) || (sgn && mag > NEG_MAG)) begin
        res.invalid = 1'b1;
        res.value   = sat_val;
      end else begin
        res.value   = sgn ? (~mag[INT_W-1:0] + 1'b1) : mag[INT_W-1:0];
        res.inexact = gbit | sbit;
      end
    end else if (sgn) begin
      if (mag != '0) res.invalid = 1'b1;
      else           res.inexact = gbit | sbit;
    end else if (mag[INT_W]) begin
      res.invalid = 1'b1;
      res.value   = sat_val;
    end else begin
      res.value   = mag[INT_W-1:0];
      res.inexact = gbit | sbit;
    end
  end

  always_comb begin
    assert (!(res.invalid && res.inexact)); // R8 flags exclusive
  end
endmodule

// File: rtl/fic_i2f.sv
module fic_i2f
  import fic_pkg::*;
(
  input  logic [INT_W-1:0] operand,
  input  logic             src_signed,
  input  rmode_e           mode,
  output cvt_res_t         res
);
  localparam int SIG_W = FRAC_W + 1;
  localparam int ZW    = $clog2(INT_W);
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int ETOP  = BIAS + INT_W - 1;

  logic             neg, gbit, sbit, incr;
  logic [INT_W-1:0] mag, norm;
  logic [ZW-1:0]    lz;
  logic [SIG_W-1:0] keep;
  logic [SIG_W:0]   sum;
  logic [EXP_W-1:0] expo;

  always_comb begin
    neg = src_signed & operand[INT_W-1];
    mag = neg ? (~operand + 1'b1) : operand;
  end

  fic_lzc #(.W(INT_W)) u_lzc (
    .vec   (mag),
    .zeros (lz)
  );

  always_comb begin
    norm = mag << lz;
    keep = norm[INT_W-1 -: SIG_W];
    gbit = norm[INT_W-1-SIG_W];
    sbit = |norm[INT_W-2-SIG_W:0];
  end

  fic_round_dec u_round (
    .mode   (mode),
    .neg    (neg),
    .lsb    (keep[0]),
    .guard  (gbit),
    .sticky (sbit),
    .incr   (incr)
  );

  always_comb begin
    sum  = {1'b0, keep} + {{SIG_W{1'b0}}, incr};
    // A carry leaves the fraction bits at zero; only the exponent moves.
    expo = EXP_W'(ETOP) - EXP_W'(lz) + EXP_W'(sum[SIG_W]);
    res  = '0;
    if (mag != '0) begin
      res.value   = {neg, expo, sum[FRAC_W-1:0]};
      res.inexact = gbit | sbit;
    end
  end
endmodule

// File: rtl/flt_int_cvt.sv
module flt_int_cvt
  import fic_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [2:0]  in_opc,
  input  logic        in_mode_bit,
  input  logic [1:0]  in_rmode,
  input  logic [31:0] in_operand,
  output logic        out_valid,
  output logic [31:0] out_result,
  output logic        out_invalid,
  output logic        out_inexact,
  output logic        out_undef
);
  logic [1:0] rst_pipe;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  logic     sel_f2i, sel_i2f, f2i_signed;
  rmode_e   f2i_mode, dyn_mode;
  cvt_res_t f2i_res, i2f_res, nxt_res;
  logic     nxt_undef;

  assign dyn_mode = rmode_e'(in_rmode);

  always_comb begin
    sel_f2i    = 1'b0;
    sel_i2f    = 1'b0;
    f2i_signed = 1'b0;
    case (opc_e'(in_opc))
      OPC_F2S: begin sel_f2i = 1'b1; f2i_signed = 1'b1; end
      OPC_F2U: sel_f2i = 1'b1;
      OPC_I2F: sel_i2f = 1'b1;
      default: ;
    endcase
    f2i_mode = in_mode_bit ? RM_ZERO : dyn_mode;
  end

  fic_f2i u_f2i (
    .operand   (in_operand),
    .to_signed (f2i_signed),
    .mode      (f2i_mode),
    .res       (f2i_res)
  );

  fic_i2f u_i2f (
    .operand    (in_operand),
    .src_signed (in_mode_bit),
    .mode       (dyn_mode),
    .res        (i2f_res)
  );

  always_comb begin
    nxt_undef = !(sel_f2i || sel_i2f);
    if (sel_f2i)      nxt_res = f2i_res;
    else if (sel_i2f) nxt_res = i2f_res;
    else              nxt_res = '0;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
      out_undef   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= nxt_res.value;
        out_invalid <= nxt_res.invalid;
        out_inexact <= nxt_res.inexact;
        out_undef   <= nxt_undef;
      end
    end
  end

  AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n_int)
    out_undef |-> (out_result == '0 && !out_invalid && !out_inexact)); // R1
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    in_valid |=> out_valid); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n_int)
    !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_invalid))); // R2
  AST_NAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n_int)
    (in_valid && (in_opc == 3'b101 || in_opc == 3'b100) &&
     (&in_operand[30:23]) && (|in_operand[22:0]))
    |=> (out_result == '0 && out_invalid)); // R7
  AST_SAT_SET: assert property (@(posedge clk) disable iff (!rst_n_int)
    out_invalid |-> (out_result == 32'h0 || out_result == 32'h7FFFFFFF ||
                     out_result == 32'h80000000 || out_result == 32'hFFFFFFFF)); // R5
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n_int)
    out_invalid |-> !out_inexact); // R8
endmodule

// File: tb/flt_int_cvt_bench.sv
module flt_int_cvt_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [2:0]  in_opc;
  logic        in_mode_bit;
  logic [1:0]  in_rmode;
  logic [31:0] in_operand;
  logic        out_valid, out_invalid, out_inexact, out_undef;
  logic [31:0] out_result;

  always #4 clk = ~clk;

  flt_int_cvt u_flt_int_cvt (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opc(in_opc),
    .in_mode_bit(in_mode_bit), .in_rmode(in_rmode), .in_operand(in_operand),
    .out_valid(out_valid), .out_result(out_result), .out_invalid(out_invalid),
    .out_inexact(out_inexact), .out_undef(out_undef)
  );

  int n_checks = 0;
  int n_errors = 0;
  int cycles   = 0;
  bit done     = 0;

  logic [31:0] m_res;
  logic        m_inv, m_inx, m_und, m_vld;
  int          m_tag;

  function automatic bit round_up(input logic [1:0] rm, input bit neg, input bit odd,
                                  input int cmp, input bit any);
    case (rm)
      2'b00:   return (cmp > 0) || (cmp == 0 && odd);
      2'b01:   return any && !neg;
      2'b10:   return any && neg;
      default: return 1'b0;
    endcase
  endfunction

  function automatic void ref_f2i(input logic [31:0] x, input bit to_s, input logic [1:0] rm,
                                  input bit forced, output logic [31:0] r, output bit iv,
                                  output bit ix, output int tg);
    bit s; int e, sh, cmp; longint sig, q, rem, half, v; bit any;
    s = x[31]; e = int'(x[30:23]); sig = longint'(x[22:0]);
    r = 0; iv = 0; ix = 0; tg = forced ? 3 : 8;
    if (e == 255) begin
      iv = 1; tg = 7;
      if (x[22:0] == 0) r = to_s ? (s ? 32'h80000000 : 32'h7FFFFFFF) : (s ? 32'h0 : 32'hFFFFFFFF);
      return;
    end
    if (e == 0) sh = 149;
    else begin sig = sig + (longint'(1) << 23); sh = 23 - (e - 127); end
    any = 0; cmp = -1;
    if (sh <= 0) begin
      if (-sh > 20) q = longint'(1) << 50;
      else q = sig << (-sh);
    end else if (sh >= 40) begin
      q = 0; any = (sig != 0);
    end else begin
      q = sig >> sh; rem = sig - (q << sh); half = longint'(1) << (sh - 1);
      any = (rem != 0); cmp = (rem > half) ? 1 : ((rem == half) ? 0 : -1);
    end
    q = q + longint'(round_up(rm, s, q[0], cmp, any));
    v = s ? -q : q;
    if (any && cmp == 0 && !forced) tg = 4;
    if (to_s) begin
      if (v > 64'sd2147483647 || v < -64'sd2147483648) begin
        r = s ? 32'h80000000 : 32'h7FFFFFFF; iv = 1; tg = 5;
      end else begin r = v[31:0]; ix = any; end
    end else begin
      if (v < 0) begin r = 0; iv = 1; tg = 6; end
      else if (v > 64'sd4294967295) begin r = 32'hFFFFFFFF; iv = 1; tg = 6; end
      else begin r = v[31:0]; ix = any; if (s && any) tg = 6; end
    end
  endfunction

  function automatic void ref_i2f(input logic [31:0] x, input bit sgn_src, input logic [1:0] rm,
                                  output logic [31:0] r, output bit ix, output int tg);
    bit neg; longint mag, q, rem, half; int p, sh, cmp; bit any;
    neg = sgn_src && x[31];
    mag = neg ? (longint'(1) << 32) - longint'({32'h0, x}) : longint'({32'h0, x});
    r = 0; ix = 0; tg = 9; p = 0;
    if (mag == 0) return;
    for (int b = 0; b < 33; b++) if (mag[b]) p = b;
    any = 0;
    if (p <= 23) q = mag << (23 - p);
    else begin
      sh = p - 23; q = mag >> sh; rem = mag - (q << sh); half = longint'(1) << (sh - 1);
      any = (rem != 0); cmp = (rem > half) ? 1 : ((rem == half) ? 0 : -1);
      q = q + longint'(round_up(rm, neg, q[0], cmp, any));
      if (q == (longint'(1) << 24)) begin q = longint'(1) << 23; p = p + 1; end
    end
    r = {neg, 8'(127 + p), q[22:0]};
    ix = any;
    if (any) tg = 10;
  endfunction

  // Cycle model: one register stage, state held while idle.
  always @(posedge clk or negedge rst_n) begin
    logic [31:0] r; bit iv, ix; int tg;
    if (!rst_n) begin
      m_res <= 0; m_inv <= 0; m_inx <= 0; m_und <= 0; m_vld <= 0; m_tag <= 11; // R11
    end else begin
      m_vld <= in_valid;
      if (in_valid) begin
        iv = 0;
        if (in_opc == 3'b101 || in_opc == 3'b100) begin
          ref_f2i(in_operand, in_opc[0], in_mode_bit ? 2'b11 : in_rmode, in_mode_bit, r, iv, ix, tg);
          m_und <= 0;
        end else if (in_opc == 3'b000) begin
          ref_i2f(in_operand, in_mode_bit, in_rmode, r, ix, tg);
          m_und <= 0;
        end else begin
          r = 0; ix = 0; tg = 1; m_und <= 1; // R1
        end
        m_res <= r; m_inv <= iv; m_inx <= ix; m_tag <= tg;
      end else begin
        m_tag <= 2; // R2 hold
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      n_checks++;
      if (out_result !== m_res || out_invalid !== m_inv || out_inexact !== m_inx ||
          out_undef !== m_und || out_valid !== m_vld) begin
        n_errors++;
        $display("FAIL R%0d: actual res=%h inv=%b inx=%b und=%b vld=%b expected res=%h inv=%b inx=%b und=%b vld=%b",
                 m_tag, out_result, out_invalid, out_inexact, out_undef, out_valid,
                 m_res, m_inv, m_inx, m_und, m_vld);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      n_errors++;
      $display("FAIL R2: watchdog expired, actual cycles=%0d expected below 20000", cycles);
      finish_run();
    end
  end

  task automatic apply(input logic [2:0] opc, input bit mb, input logic [1:0] rm, input logic [31:0] v);
    @(negedge clk);
    in_valid = 1; in_opc = opc; in_mode_bit = mb; in_rmode = rm; in_operand = v;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_opc = 3'($urandom); in_operand = $urandom;
  endtask

  initial begin
    rst_n = 0; in_valid = 0; in_opc = 0; in_mode_bit = 0; in_rmode = 0; in_operand = 0;
    repeat (4) @(negedge clk);            // R11: outputs checked as zero during reset
    rst_n = 1;
    repeat (4) idle();                     // R11: still zero after release
    apply(3'b101, 1, 2'b00, 32'h40200000); // R3 2.5 truncated -> 2
    apply(3'b101, 0, 2'b00, 32'h40200000); // R4 tie -> 2
    apply(3'b101, 0, 2'b00, 32'h40600000); // R4 tie -> 4
    apply(3'b101, 0, 2'b01, 32'h40200000); // R3 up -> 3
    apply(3'b101, 0, 2'b10, 32'hC0200000); // R3 down -> -3
    apply(3'b101, 0, 2'b11, 32'hC0200000); // R3 zero -> -2
    idle();                                // R2 hold
    idle();
    apply(3'b101, 1, 2'b00, 32'h4F000000); // R5 2^31 saturates
    apply(3'b101, 1, 2'b00, 32'hCF000000); // R5 -2^31 exact
    apply(3'b101, 1, 2'b00, 32'hCF000001); // R5 below -2^31
    apply(3'b100, 1, 2'b00, 32'h4F800000); // R6 2^32 saturates
    apply(3'b100, 1, 2'b00, 32'h4F7FFFFF); // R6 largest in range
    apply(3'b100, 1, 2'b00, 32'hBF800000); // R6 -1.0 invalid
    apply(3'b100, 1, 2'b00, 32'hBE99999A); // R6 -0.3 inexact only
    apply(3'b100, 0, 2'b10, 32'hBE99999A); // R6 -0.3 down -> invalid
    apply(3'b100, 0, 2'b00, 32'h80000000); // R6 -0 no flag
    apply(3'b101, 0, 2'b00, 32'h7FC00000); // R7 NaN
    apply(3'b101, 0, 2'b00, 32'h7F800000); // R7 +inf
    apply(3'b100, 0, 2'b00, 32'hFF800000); // R7 -inf unsigned
    apply(3'b101, 0, 2'b01, 32'h00000001); // R8 subnormal up -> 1
    apply(3'b101, 0, 2'b00, 32'h3F000001); // R8 just above half
    apply(3'b000, 1, 2'b00, 32'hFFFFFFFF); // R9 -1
    apply(3'b000, 1, 2'b00, 32'h80000000); // R9 most negative
    apply(3'b000, 1, 2'b00, 32'h00000000); // R9 zero -> +0
    apply(3'b000, 0, 2'b00, 32'hFFFFFFFF); // R10 carry into exponent
    apply(3'b000, 0, 2'b11, 32'hFFFFFFFF); // R10 truncated
    apply(3'b000, 0, 2'b00, 32'h01000001); // R10 tie to even
    apply(3'b000, 1, 2'b10, 32'hFEFFFFFF); // R10 signed, toward -inf
    apply(3'b001, 0, 2'b00, 32'h40200000); // R1 undefined
    apply(3'b110, 1, 2'b01, 32'h12345678); // R1 undefined
    apply(3'b111, 0, 2'b00, 32'h7FC00000); // R1 undefined
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] v;
      logic [2:0]  opc;
      case ($urandom_range(0, 9))
        0:       opc = 3'($urandom);
        1, 2, 3: opc = 3'b000;
        4, 5, 6: opc = 3'b100;
        default: opc = 3'b101;
      endcase
      if (opc == 3'b000) v = ($urandom_range(0, 1) == 1) ? $urandom : ($urandom >> $urandom_range(0, 31));
      else if ($urandom_range(0, 3) == 0) v = $urandom;
      else v = {1'($urandom), 8'(118 + $urandom_range(0, 42)), 23'($urandom)};
      if ($urandom_range(0, 7) == 0) idle();
      else apply(opc, 1'($urandom), 2'($urandom), v);
    end
    idle();
    idle();
    finish_run();
  end
endmodule